// File: doc/BRIEF.md
# Carry-Pipelined Phase Accumulator

This block is the phase accumulator of a numerically controlled oscillator. On every clock it adds an increment word to a 32-bit phase register. The top bit of the phase is the square-wave oscillator output, and the whole phase word is also given out. Two consecutive 32-bit phase values differ by the increment, so the increment sets the output frequency as a fraction of the clock.

A single 32-bit add in a feedback loop limits the clock rate, so the adder is cut into narrow slices. The carry-out of each slice goes into a register and is added into the next higher slice one cycle later. Slice k therefore works k cycles behind slice 0. To make that correct, the increment bits for slice k pass through k skew registers, so each slice adds bits of the same logical increment. On the output side the lower slices are delayed by deskew registers, which puts all slices back in step. The phase word and the oscillator bit are therefore always coherent, at a fixed latency of slices minus one cycles.

When the increment port is narrower than the phase, the slices above it carry no increment bits. Such a slice only counts up when the registered carry from the slice below is set.

Top module: `nco_carry_accum`

## Requirements
- R1: Let the increment sampled at clock edge i be inc(i), with edge 1 the first rising edge after reset is released. After edge n, `phaseOut` equals the sum of inc(1) through inc(n-3), taken modulo 2^32 (default of four 8-bit slices).
- R2: `oscOut` always equals bit 31 of `phaseOut`. This bit is the MSB of the delayed phase, so an increment of 32'h8000_0000 makes it toggle on every cycle.
- R3: While `rstN` is low, `phaseOut` and `oscOut` are zero. They go to zero at once, without waiting for a clock edge. Increments presented during reset have no effect on any later output.
- R4: Carries cross every slice boundary without loss. From 0 the sum 32'h00FF_FFFF + 1 reads 32'h0100_0000. Wraparound at 2^32 is exact, so 32'hFFFF_FFFF + 1 reads 0.
- R5: An increment that changes on every cycle is applied exactly once per cycle, with each slice adding the bits of the same logical increment.
- R6: With an increment port narrower than the phase (parameter INC_W), the increment is zero-extended. Slices above it change only when the registered carry from below is set, and the result still matches R1.
- R7: The latency is fixed at NUM_SLICES-1 cycles. For the first three edges after reset is released, `phaseOut` stays zero whatever the increment is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| incWord | input | INC_W | Phase increment, sampled every rising edge |
| oscOut | output | 1 | Oscillator bit, MSB of the aligned phase |
| phaseOut | output | PHASE_W | Aligned phase word |

## Verification
An increment sampled at one rising edge first shows in `phaseOut` and `oscOut` three edges later. The reset clear, by contrast, shows at once and needs no edge. The bench keeps its own plain accumulator and a four-deep history of its values. At each falling edge it compares the outputs with the history entry from three edges back. It checks the immediate clear one time unit after pulling reset low, before any edge has occurred. The narrow instance is checked against its own zero-extended model on the same cycles.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Number of increment bits that fall into slice k (0 if the slice is above the increment).
  function automatic int sliceIncBits(input int k, input int sliceW, input int incW);
    int lo;
    lo = k * sliceW;
    if (lo >= incW) return 0;
    if (incW - lo < sliceW) return incW - lo;
    return sliceW;
  endfunction

endpackage

// File: rtl/nco_delay.sv
module nco_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dataIn,
  output logic [W-1:0] dataOut
);
  logic [DEPTH-1:0][W-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
    end else begin
      stage[0] <= dataIn;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign dataOut = stage[DEPTH-1];
endmodule

// File: rtl/nco_add_slice.sv
module nco_add_slice #(
  parameter int W        = 8,
  parameter int INC_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [INC_BITS-1:0] incIn,
  input  logic                carryIn,
  output logic [W-1:0]        sliceQ,
  output logic                carryQ
);
  logic [W:0] sum;

  always_comb sum = {1'b0, sliceQ} + (W+1)'(incIn) + (W+1)'(carryIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sliceQ <= '0;
      carryQ <= 1'b0;
    end else begin
      sliceQ <= sum[W-1:0];
      carryQ <= sum[W];
    end
  end

  // R4: a registered carry means the slice wrapped (did not grow)
  assert_wrap_carry_R4: assert property (@(posedge clk) disable iff (!rstN)
    carryQ |-> (sliceQ <= $past(sliceQ)));
  // R4: no carry means the slice did not wrap
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    !carryQ |-> (sliceQ >= $past(sliceQ)));
endmodule

// File: rtl/nco_inc_slice.sv
module nco_inc_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         carryIn,
  output logic [W-1:0] sliceQ,
  output logic         carryQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sliceQ <= '0;
      carryQ <= 1'b0;
    end else begin
      sliceQ <= sliceQ + W'(carryIn);
      carryQ <= carryIn & (&sliceQ);
    end
  end

  // R6: an upper slice changes only when the carry from below enabled it
  assert_enable_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sliceQ != $past(sliceQ)) |-> $past(carryIn));
  // R6: a carry out comes only from an all-ones slice rolling to zero
  assert_carry_rollover_R6: assert property (@(posedge clk) disable iff (!rstN)
    carryQ |-> (($past(sliceQ) == '1) && (sliceQ == '0)));
endmodule

// File: rtl/nco_carry_accum.sv
module nco_carry_accum #(
  parameter int PHASE_W = 32,
  parameter int SLICE_W = 8,
  parameter int INC_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INC_W-1:0]   incWord,
  output logic               oscOut,
  output logic [PHASE_W-1:0] phaseOut
);
  localparam int NUM_SLICES = PHASE_W / SLICE_W;
  localparam int LAT        = NUM_SLICES - 1;
  localparam int CW         = $clog2(LAT + 2);

  logic [NUM_SLICES:0]                    carryChain;
  logic [NUM_SLICES-1:0][SLICE_W-1:0]     sliceVal;

  assign carryChain[0] = 1'b0;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    localparam int LO = k * SLICE_W;
    localparam int NB = nco_pkg::sliceIncBits(k, SLICE_W, INC_W);

    if (NB > 0) begin : g_add
      logic [NB-1:0] incAligned;
      if (k == 0) begin : g_noskew
        assign incAligned = incWord[LO +: NB];
      end else begin : g_skew
        nco_delay #(.W(NB), .DEPTH(k)) u_skew (
          .clk(clk), .rstN(rstN), .dataIn(incWord[LO +: NB]), .dataOut(incAligned));
      end
      nco_add_slice #(.W(SLICE_W), .INC_BITS(NB)) u_slice (
        .clk(clk), .rstN(rstN), .incIn(incAligned), .carryIn(carryChain[k]),
        .sliceQ(sliceVal[k]), .carryQ(carryChain[k+1]));
    end else begin : g_inc
      nco_inc_slice #(.W(SLICE_W)) u_slice (
        .clk(clk), .rstN(rstN), .carryIn(carryChain[k]),
        .sliceQ(sliceVal[k]), .carryQ(carryChain[k+1]));
    end

    if (k == NUM_SLICES - 1) begin : g_top
      assign phaseOut[LO +: SLICE_W] = sliceVal[k];
    end else begin : g_deskew
      nco_delay #(.W(SLICE_W), .DEPTH(LAT - k)) u_deskew (
        .clk(clk), .rstN(rstN), .dataIn(sliceVal[k]), .dataOut(phaseOut[LO +: SLICE_W]));
    end
  end

  assign oscOut = phaseOut[PHASE_W-1];

  // Cycles since reset release, saturating just above the latency (assertion use)
  logic [CW-1:0] primeCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       primeCnt <= '0;
    else if (primeCnt <= CW'(LAT))   primeCnt <= primeCnt + 1'b1;
  end

  // R3: everything is clear while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_clear_R3: assert (phaseOut == '0 && carryChain == '0)
        else $error("phase or carries not clear in reset");
    end
  end

  // R7: output stays zero until the pipeline has filled
  assert_prime_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (primeCnt <= CW'(LAT)) |-> (phaseOut == '0));
endmodule

// File: tb/tb_nco_carry_accum.sv
module tb_nco_carry_accum;
  localparam int LAT = 3;
  localparam int NW  = 12;
  localparam int NT  = 7;
  localparam logic [31:0] INC_TAB [NT] = '{32'h0000_0001, 32'h1234_5678, 32'h8000_0000,
                                           32'hFFFF_FFFF, 32'h00FF_FFFF, 32'h7FFF_FFFF,
                                           32'hDEAD_BEEF};
  localparam int REP_TAB [NT] = '{5, 20, 6, 10, 12, 9, 15};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] incWord = '0;
  logic [NW-1:0] incNarrow = '0;
  logic oscOut, oscNarrow;
  logic [31:0] phaseOut, phaseNarrow;

  int nChecks = 0;
  int nErrors = 0;
  logic [31:0] accWide, accNarrow;
  logic [31:0] histW [0:LAT];
  logic [31:0] histN [0:LAT];

  always #4 clk = ~clk;

  nco_carry_accum dut (.clk(clk), .rstN(rstN), .incWord(incWord),
                       .oscOut(oscOut), .phaseOut(phaseOut));
  nco_carry_accum #(.INC_W(NW)) dutNarrow (.clk(clk), .rstN(rstN), .incWord(incNarrow),
                       .oscOut(oscNarrow), .phaseOut(phaseNarrow));

  task automatic checkEq(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clearModel();
    accWide = '0; accNarrow = '0;
    for (int j = 0; j <= LAT; j++) begin histW[j] = '0; histN[j] = '0; end
  endtask

  // One cycle: drive, let the edge sample, then check at the falling edge.
  task automatic runCycle(input logic [31:0] incV, input string req);
    incWord = incV;
    incNarrow = incV[NW-1:0];
    @(posedge clk);
    accWide = accWide + incV;
    accNarrow = accNarrow + {{(32-NW){1'b0}}, incV[NW-1:0]};
    for (int j = LAT; j > 0; j--) begin histW[j] = histW[j-1]; histN[j] = histN[j-1]; end
    histW[0] = accWide; histN[0] = accNarrow;
    @(negedge clk);
    checkEq({req, " R1 phase"}, phaseOut, histW[LAT]);
    checkEq("R2 osc bit", {31'd0, oscOut}, {31'd0, histW[LAT][31]});
    checkEq("R6 narrow phase", phaseNarrow, histN[LAT]);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    incWord = 32'hA5A5_A5A5; incNarrow = 12'hA5A;
    #1;
    checkEq("R3 async clear", phaseOut, 32'h0);
    checkEq("R3 async clear narrow", phaseNarrow, 32'h0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      checkEq("R3 held in reset", phaseOut, 32'h0);
    end
    rstN = 1'b1;
    clearModel();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks + 1);
    $finish;
  end

  initial begin
    clearModel();
    repeat (2) @(negedge clk);
    checkEq("R3 reset state", phaseOut, 32'h0);
    checkEq("R3 reset osc", {31'd0, oscOut}, 32'h0);
    rstN = 1'b1;

    // R7: first LAT outputs stay zero, then the first increment appears
    for (int c = 0; c < LAT; c++) begin
      runCycle(32'h0000_0005, "R7");
      checkEq("R7 prime zero", phaseOut, 32'h0);
    end
    runCycle(32'h0, "R7");
    checkEq("R7 first value", phaseOut, 32'h0000_0005);

    // Table walk (R1, R2 toggle, R4 wrap)
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < REP_TAB[t]; r++) runCycle(INC_TAB[t], "table");

    // R5: a new increment on every cycle
    for (int i = 0; i < 40; i++) runCycle((32'h9E37_79B9 * i) ^ (i << 17), "R5");

    // R3: reset mid-run, then exact carry and wrap corners (R4)
    doReset();
    runCycle(32'h00FF_FFFF, "R4");
    runCycle(32'h0000_0001, "R4");
    for (int c = 0; c < LAT; c++) runCycle(32'h0, "R4");
    checkEq("R4 carry chain", phaseOut, 32'h0100_0000);
    runCycle(32'hFEFF_FFFF, "R4");
    for (int c = 0; c < LAT; c++) runCycle(32'h0, "R4");
    checkEq("R4 all ones", phaseOut, 32'hFFFF_FFFF);
    checkEq("R2 osc high", {31'd0, oscOut}, 32'h1);
    runCycle(32'h0000_0001, "R4");
    for (int c = 0; c < LAT; c++) runCycle(32'h0, "R4");
    checkEq("R4 wrap to zero", phaseOut, 32'h0);

    // R6: narrow increments that ripple through the upper slices
    for (int i = 0; i < 30; i++) runCycle(32'h0000_0FFF - i, "R6");

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule